// File: doc/BRIEF.md
# Version-Tagged Compare-and-Swap Unit

This block holds a small bank of shared words and performs atomic compare-and-swap on them for a lock-free software structure such as a stack of free slots. Each word is twice the pointer width. The low half holds a pointer or slot index. The high half holds a version tag that only the unit advances. A requester supplies a word address, the pointer and tag it last observed, and the pointer it wants to install. The swap happens only when both halves still equal what the requester saw. On a swap the unit stores the new pointer together with the old tag plus one.

Because the tag moves on every successful swap, a location whose pointer is changed away and then changed back no longer matches a requester holding the old tag. That requester is refused. A false match can only occur if the tag wraps all the way round and the pointer also happens to coincide. Every response carries a success flag and the full word as found, so a refused requester can retry without a separate read.

A parameter picks a 16+16 or a 32+32 word split. A plain write port loads a pointer with the tag at zero. Reset clears every word. Requests use a valid/ready handshake. Each accepted request gets exactly one response, two cycles after acceptance.

Top module: `cas_vtag_unit`

## Requirements
- R1: While rst_ni is low, req_ready_o and rsp_valid_o are 0 and every word is cleared to zero. From the first clock edge after reset is released, req_ready_o is 1 and stays 1.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. rsp_valid_o is 1 for exactly one cycle, in the second cycle after the acceptance cycle. No response appears without an accepted request.
- R3: When the stored word equals {req_exp_tag_i, req_exp_ptr_i}, with the tag in the upper half, rsp_ok_o is 1. The word becomes {stored tag + 1, req_new_ptr_i}.
- R4: When either the pointer half or the tag half differs from the expectation, rsp_ok_o is 0 and the word is left unchanged.
- R5: rsp_word_o is the complete word as found by the operation, tag in the upper half and pointer in the lower half, whether the swap succeeds or fails.
- R6: The tag increment wraps modulo 2^PTR_W, so an all-ones tag becomes zero on a successful swap.
- R7: After a word is swapped away from a pointer and back to it, a request that expects the original pointer with the original tag is refused.
- R8: A plain write with wr_en_i stores {0, wr_ptr_i}, that is, the pointer with a zero tag.
- R9: Requests accepted on consecutive cycles to the same word are applied in order. The second one compares against the result of the first.
- R10: A plain write issued in the same cycle that an earlier request is evaluated, to the same word, is ordered before that request. The request compares against the written value, and its successful swap overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | ADDR_W | Word address |
| req_exp_ptr_i | input | PTR_W | Expected pointer half |
| req_exp_tag_i | input | PTR_W | Expected tag half |
| req_new_ptr_i | input | PTR_W | Pointer to install on success |
| wr_en_i | input | 1 | Plain write enable |
| wr_addr_i | input | ADDR_W | Plain write address |
| wr_ptr_i | input | PTR_W | Plain write pointer; the tag is set to zero |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ok_o | output | 1 | Swap performed |
| rsp_word_o | output | 2*PTR_W | Word as found: {tag, pointer} |

## Verification
The bench drives a pointer away and back and then presents the stale tag. A unit that compared only the pointer would accept that swap, which is the false match the tag exists to stop. It streams 65536 back-to-back successful swaps into one word so the tag wraps. A unit that saturated, or that read a stale word for the second of two consecutive requests, would then report failures or wrong found words. It also collides a plain write with an in-flight request to the same word. A unit that ordered the two the other way would refuse the swap or let the plain write survive.

// File: rtl/cas_vtag_pkg.sv
package cas_vtag_pkg;

  typedef enum logic {
    SPLIT_16_16 = 1'b0,
    SPLIT_32_32 = 1'b1
  } split_e;

  function automatic int ptr_width(split_e s);
    return (s == SPLIT_32_32) ? 32 : 16;
  endfunction

endpackage

// File: rtl/cas_vtag_ingress.sv
// Request acceptance and stage-1 capture.
module cas_vtag_ingress #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PTR_W-1:0]  req_exp_ptr_i,
  input  logic [PTR_W-1:0]  req_exp_tag_i,
  input  logic [PTR_W-1:0]  req_new_ptr_i,
  output logic              ready_o,
  output logic              s1_valid_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic [2*PTR_W-1:0] s1_exp_o,
  output logic [PTR_W-1:0]  s1_new_ptr_o
);

  logic ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q      <= 1'b0;
      s1_valid_o   <= 1'b0;
      s1_addr_o    <= '0;
      s1_exp_o     <= '0;
      s1_new_ptr_o <= '0;
    end else begin
      ready_q    <= 1'b1;
      s1_valid_o <= req_valid_i & ready_q;
      if (req_valid_i && ready_q) begin
        s1_addr_o    <= req_addr_i;
        s1_exp_o     <= {req_exp_tag_i, req_exp_ptr_i};
        s1_new_ptr_o <= req_new_ptr_i;
      end
    end
  end

  assign ready_o = ready_q;

endmodule

// File: rtl/cas_vtag_store.sv
// Word bank: port b (swap commit) wins over port a (plain write) on the same word.
module cas_vtag_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [WORD_W-1:0] a_data_i,
  input  logic              b_en_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [WORD_W-1:0] b_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit_a;
    logic              hit_b;

    assign hit_a = a_en_i && (a_addr_i == ADDR_W'(i));
    assign hit_b = b_en_i && (b_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    word_q <= '0;
      else if (hit_b) word_q <= b_data_i;
      else if (hit_a) word_q <= a_data_i;
    end

    assign words[i] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];

endmodule

// File: rtl/cas_vtag_eval.sv
// Compare and next-word computation; a same-cycle plain write is seen first.
module cas_vtag_eval #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic [2*PTR_W-1:0] rd_word_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [PTR_W-1:0]   wr_ptr_i,
  input  logic [ADDR_W-1:0]  s1_addr_i,
  input  logic [2*PTR_W-1:0] s1_exp_i,
  input  logic [PTR_W-1:0]   s1_new_ptr_i,
  output logic [2*PTR_W-1:0] seen_o,
  output logic               match_o,
  output logic [2*PTR_W-1:0] commit_o
);

  localparam int WORD_W = 2 * PTR_W;

  logic [PTR_W-1:0] seen_tag;

  always_comb begin
    if (wr_en_i && (wr_addr_i == s1_addr_i)) seen_o = {{PTR_W{1'b0}}, wr_ptr_i};
    else                                     seen_o = rd_word_i;
  end

  assign seen_tag = seen_o[WORD_W-1:PTR_W];
  assign match_o  = (seen_o == s1_exp_i);
  assign commit_o = {seen_tag + PTR_W'(1), s1_new_ptr_i};

endmodule

// File: rtl/cas_vtag_unit.sv
module cas_vtag_unit #(
  parameter cas_vtag_pkg::split_e SPLIT = cas_vtag_pkg::SPLIT_16_16,
  parameter int DEPTH = 16,
  localparam int PTR_W  = cas_vtag_pkg::ptr_width(SPLIT),
  localparam int WORD_W = 2 * PTR_W,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PTR_W-1:0]  req_exp_ptr_i,
  input  logic [PTR_W-1:0]  req_exp_tag_i,
  input  logic [PTR_W-1:0]  req_new_ptr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic [WORD_W-1:0] rsp_word_o
);

  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s1_exp;
  logic [PTR_W-1:0]  s1_new_ptr;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] seen;
  logic [WORD_W-1:0] commit;
  logic              match;

  cas_vtag_ingress #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ingress (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_addr_i    (req_addr_i),
    .req_exp_ptr_i (req_exp_ptr_i),
    .req_exp_tag_i (req_exp_tag_i),
    .req_new_ptr_i (req_new_ptr_i),
    .ready_o       (req_ready_o),
    .s1_valid_o    (s1_valid),
    .s1_addr_o     (s1_addr),
    .s1_exp_o      (s1_exp),
    .s1_new_ptr_o  (s1_new_ptr)
  );

  cas_vtag_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (wr_en_i),
    .a_addr_i  (wr_addr_i),
    .a_data_i  ({{PTR_W{1'b0}}, wr_ptr_i}),
    .b_en_i    (s1_valid & match),
    .b_addr_i  (s1_addr),
    .b_data_i  (commit),
    .rd_addr_i (s1_addr),
    .rd_data_o (rd_word)
  );

  cas_vtag_eval #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_eval (
    .rd_word_i    (rd_word),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_ptr_i     (wr_ptr_i),
    .s1_addr_i    (s1_addr),
    .s1_exp_i     (s1_exp),
    .s1_new_ptr_i (s1_new_ptr),
    .seen_o       (seen),
    .match_o      (match),
    .commit_o     (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_word_o  <= '0;
    end else begin
      rsp_valid_o <= s1_valid;
      if (s1_valid) begin
        rsp_ok_o   <= match;
        rsp_word_o <= seen;
      end
    end
  end

endmodule

// File: rtl/cas_vtag_chk.sv
module cas_vtag_chk #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic [PTR_W-1:0]   req_exp_ptr_i,
  input logic [PTR_W-1:0]   req_exp_tag_i,
  input logic [PTR_W-1:0]   req_new_ptr_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [PTR_W-1:0]   wr_ptr_i,
  input logic               rsp_valid_o,
  input logic               rsp_ok_o,
  input logic [2*PTR_W-1:0] rsp_word_o
);

  localparam int WORD_W = 2 * PTR_W;

  logic              c1_v, c2_v;
  logic [ADDR_W-1:0] c1_addr, c2_addr;
  logic [PTR_W-1:0]  c1_tag, c2_tag, c1_ptr, c2_ptr, c1_new, c2_new;
  logic              chain_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_v <= 1'b0; c2_v <= 1'b0;
      c1_addr <= '0; c2_addr <= '0;
      c1_tag <= '0; c2_tag <= '0;
      c1_ptr <= '0; c2_ptr <= '0;
      c1_new <= '0; c2_new <= '0;
    end else begin
      c1_v    <= req_valid_i & req_ready_o;
      c1_addr <= req_addr_i;
      c1_tag  <= req_exp_tag_i;
      c1_ptr  <= req_exp_ptr_i;
      c1_new  <= req_new_ptr_i;
      c2_v    <= c1_v;
      c2_addr <= c1_addr;
      c2_tag  <= c1_tag;
      c2_ptr  <= c1_ptr;
      c2_new  <= c1_new;
    end
  end

  // Next request hits the same word with no plain write in between.
  assign chain_next = c1_v && (c1_addr == c2_addr) && !(wr_en_i && (wr_addr_i == c1_addr));

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!rsp_valid_o && !req_ready_o));

  p_ready_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_ready_o) |-> req_ready_o);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ##1 rsp_valid_o);

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> c2_v);

  p_ok_iff_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_ok_o == (rsp_word_o == {c2_tag, c2_ptr})));

  p_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ok_o && chain_next)
      |=> (rsp_word_o == {$past(c2_tag) + PTR_W'(1), $past(c2_new)}));

  p_tag_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ok_o && (&c2_tag) && chain_next)
      |=> (rsp_word_o[WORD_W-1:PTR_W] == '0));

  p_write_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(wr_en_i) && ($past(wr_addr_i) == c2_addr))
      |-> (rsp_word_o == {{PTR_W{1'b0}}, $past(wr_ptr_i)}));

endmodule

bind cas_vtag_unit cas_vtag_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_addr_i    (req_addr_i),
  .req_exp_ptr_i (req_exp_ptr_i),
  .req_exp_tag_i (req_exp_tag_i),
  .req_new_ptr_i (req_new_ptr_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_ptr_i      (wr_ptr_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ok_o      (rsp_ok_o),
  .rsp_word_o    (rsp_word_o)
);

// File: tb/tb_cas_vtag_unit.sv
`timescale 1ns/1ps
module tb_cas_vtag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        ready;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_eptr = '0, req_etag = '0, req_nptr = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_ptr = '0;
  logic        rsp_valid, rsp_ok;
  logic [31:0] rsp_word;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cas_vtag_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready),
    .req_addr_i(req_addr), .req_exp_ptr_i(req_eptr), .req_exp_tag_i(req_etag),
    .req_new_ptr_i(req_nptr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_ptr_i(wr_ptr),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .rsp_word_o(rsp_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, evaluated on each rising edge.
  logic [31:0] m_mem [16];
  logic        m_ready = 1'b0, m_s1_v = 1'b0, m_rsp_v = 1'b0, m_ok = 1'b0;
  logic [3:0]  m_s1_a = '0;
  logic [15:0] m_s1_et = '0, m_s1_ep = '0, m_s1_np = '0;
  logic [31:0] m_word = '0, m_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      m_ready = 1'b0; m_s1_v = 1'b0; m_rsp_v = 1'b0;
    end else begin
      if (wr_en) m_mem[wr_addr] = {16'h0, wr_ptr};
      m_rsp_v = m_s1_v;
      if (m_s1_v) begin
        m_seen = m_mem[m_s1_a];
        m_word = m_seen;
        m_ok   = (m_seen == {m_s1_et, m_s1_ep});
        if (m_ok) m_mem[m_s1_a] = {m_seen[31:16] + 16'd1, m_s1_np};
      end
      m_s1_v = req_valid && m_ready;
      if (m_s1_v) begin
        m_s1_a = req_addr; m_s1_et = req_etag; m_s1_ep = req_eptr; m_s1_np = req_nptr;
      end
      m_ready = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 ready", 64'(ready), 64'(m_ready));
      chk("R2 rsp_valid", 64'(rsp_valid), 64'(m_rsp_v));
      if (m_rsp_v) begin
        chk("R3 rsp_ok", 64'(rsp_ok), 64'(m_ok));
        chk("R5 rsp_word", 64'(rsp_word), 64'(m_word));
      end
    end
  end

  task automatic do_cas(input logic [3:0] a, input logic [15:0] et, input logic [15:0] ep,
                        input logic [15:0] np, output logic ok, output logic [31:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_etag = et; req_eptr = ep; req_nptr = np;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 single response", 64'(rsp_valid), 64'd1);
    ok = rsp_ok;
    w  = rsp_word;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_ptr = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic        ok;
    logic [31:0] w;

    // R1/R2: reset holds outputs low and ignores requests
    req_valid = 1'b1; req_addr = 4'd3;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 64'(ready), 64'd0);
    chk("R1 rsp_valid low in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 64'(ready), 64'd1);
    @(negedge clk);
    chk("R2 no response for reset-time request", 64'(rsp_valid), 64'd0);

    do_cas(4'd3, 16'h0001, 16'h0000, 16'h0000, ok, w);
    chk("R1 word cleared", 64'(w), 64'h0);
    chk("R4 tag mismatch fails", 64'(ok), 64'd0);
    @(negedge clk);
    chk("R2 response lasts one cycle", 64'(rsp_valid), 64'd0);

    // R8 plain write zero tag
    do_write(4'd2, 16'h1234);
    do_cas(4'd2, 16'h0007, 16'h0000, 16'h0000, ok, w);
    chk("R8 plain write word", 64'(w), 64'h0000_1234);

    // R3/R5 success
    do_cas(4'd2, 16'h0000, 16'h1234, 16'h5678, ok, w);
    chk("R3 match ok", 64'(ok), 64'd1);
    chk("R5 found word on success", 64'(w), 64'h0000_1234);

    // R4 pointer mismatch, word as found and unchanged
    do_cas(4'd2, 16'h0001, 16'h9999, 16'hAAAA, ok, w);
    chk("R4 pointer mismatch fails", 64'(ok), 64'd0);
    chk("R3 new word with tag+1", 64'(w), 64'h0001_5678);
    do_cas(4'd2, 16'h0000, 16'h5678, 16'hBBBB, ok, w);
    chk("R4 stale tag fails", 64'(ok), 64'd0);
    chk("R4 word unchanged", 64'(w), 64'h0001_5678);

    // R7 away and back
    do_write(4'd4, 16'h00AA);
    do_cas(4'd4, 16'h0000, 16'h00AA, 16'h00BB, ok, w);
    chk("R7 step away ok", 64'(ok), 64'd1);
    do_cas(4'd4, 16'h0001, 16'h00BB, 16'h00AA, ok, w);
    chk("R7 step back ok", 64'(ok), 64'd1);
    do_cas(4'd4, 16'h0000, 16'h00AA, 16'h00CC, ok, w);
    chk("R7 stale expectation refused", 64'(ok), 64'd0);
    chk("R7 found word", 64'(w), 64'h0002_00AA);

    // R9 back-to-back on one word
    do_write(4'd6, 16'h0060);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'd6; req_etag = 16'h0000; req_eptr = 16'h0060; req_nptr = 16'h0061;
    @(negedge clk);
    req_etag = 16'h0001; req_eptr = 16'h0061; req_nptr = 16'h0062;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 first ok", 64'(rsp_ok), 64'd1);
    @(negedge clk);
    chk("R9 second sees first", 64'(rsp_word), 64'h0001_0061);
    chk("R9 second ok", 64'(rsp_ok), 64'd1);

    // R10 plain write colliding with evaluation
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'd7; req_etag = 16'h0000; req_eptr = 16'h0777; req_nptr = 16'h0888;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b1; wr_addr = 4'd7; wr_ptr = 16'h0777;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 compare sees plain write", 64'(rsp_ok), 64'd1);
    chk("R10 found word", 64'(rsp_word), 64'h0000_0777);
    do_cas(4'd7, 16'h00FF, 16'h0000, 16'h0000, ok, w);
    chk("R10 swap overwrote plain write", 64'(w), 64'h0001_0888);

    // R6 tag wrap: 65536 back-to-back swaps on word 5
    do_write(4'd5, 16'h0005);
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 4'd5; req_etag = 16'(k); req_eptr = 16'h0005; req_nptr = 16'h0005;
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 last swap ok", 64'(rsp_ok), 64'd1);
    chk("R6 last found word", 64'(rsp_word), 64'hFFFF_0005);
    do_cas(4'd5, 16'h0001, 16'h0000, 16'h0000, ok, w);
    chk("R6 tag wrapped to zero", 64'(w), 64'h0000_0005);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule